// File: doc/BRIEF.md
# Shadowed Single/Double-Edge Pulse-Width Modulator

This block is a timer-driven pulse-width modulator with six outputs. A prescaler divides the clock into count ticks, and a counter advances on each tick. Seven compare values are checked against the count. Compare value 0 sets the period: in modulation mode the count returns to zero when it matches. The other six compare values place the edges of the outputs.

Each output can be single-edge or double-edge. A single-edge output rises at the start of every period and falls at its own compare. A double-edge output rises at the previous compare and falls at its own compare. Swapping the order of the two compare values turns a positive pulse into a negative pulse.

Compare values are written to shadow copies. Software marks the copies it wants applied, and they move into the active set together at the next period wrap, so no pulse is ever formed from a mix of old and new values. With modulation mode off, the block is a plain timer: compare writes apply at once, and every compare can flag an interrupt, clear the count or halt the count. Software reaches the block through a simple single-cycle register bus.

Top module: `pwm_dual_edge`

## Requirements
- R1: After reset, every register reads zero, all six outputs are low and `irq` is low.
- R2: While CTRL (address 0) bit 0 "run" is set, the count (readable at address 2) advances once every PRESC+1 clocks, where PRESC is at address 1. The count holds while no tick occurs.
- R3: When CTRL bit 2 "modulate" is set, a match on compare 0 returns the count to zero on that tick. The period is therefore (M0+1)·(PRESC+1) clocks.
- R4: Output n is single-edge when OUTCFG (address 5) bit n-1 is 0. It rises on the compare 0 match and falls on the compare n match. Per period it is high for (Mn+1) ticks when Mn<M0, never high when Mn=M0 (the falling edge wins a tie), and always high when Mn>M0.
- R5: Output n is double-edge when OUTCFG bit n-1 is 1. It rises on the compare n-1 match and falls on the compare n match, and the falling edge wins a tie. With a=M(n-1) and b=Mn, the high time per period is b-a ticks if a<b, M0+1-(a-b) ticks if a>b, and zero if a=b.
- R6: In modulation mode, a write to compare k (address 8+k) changes only its shadow copy, and the waveform is unchanged until that compare is released.
- R7: Writing 1 to bit k of RELEASE (address 6) marks compare k as pending, and the mark reads back. At the next compare 0 match, every pending shadow is copied to the active set and all pending marks clear. Compares that are not pending keep their active value.
- R8: OUTCFG bit 8+n-1 enables output n. When this bit is clear, the output is held low.
- R9: With CTRL bit 2 clear, every output is low and compare writes take effect at once, without a release.
- R10: ACTION (address 3) holds three bits for each compare k: bit 3k raises a flag, bit 3k+1 clears the count, and bit 3k+2 halts it. A flag sets bit k of FLAGS (address 4) on the match and stays set until 1 is written to that bit. `irq` is high while any flag is set.
- R11: On a match whose halt bit is set, the count holds at the matched value and CTRL bit 0 clears.
- R12: While CTRL bit 1 "clear" is set, the count and the prescaler are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid in the same cycle as the address |
| pwm_out | output | 6 | Modulated outputs, bit n-1 is output n |
| irq | output | 1 | High while any match flag is set |

## Verification
A wrong active compare or a stuck pending mark shows up one period after release: the high-time count of the affected output is off, or the RELEASE readback does not return to zero. A slip in the prescaler or wrap logic changes the count seen in the same window, because the period and every duty value scale with it. Edge-priority faults appear only when set and reset fall on the same tick. The sweeps therefore cover every ordered pair of compare values, including equal pairs and values at or above the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PWM_OUTS    = 6;
  localparam int PWM_MATCHES = PWM_OUTS + 1;
  localparam int BUS_AW      = 4;

  localparam logic [BUS_AW-1:0] A_CTRL    = 4'h0;
  localparam logic [BUS_AW-1:0] A_PRESC   = 4'h1;
  localparam logic [BUS_AW-1:0] A_COUNT   = 4'h2;
  localparam logic [BUS_AW-1:0] A_ACTION  = 4'h3;
  localparam logic [BUS_AW-1:0] A_FLAGS   = 4'h4;
  localparam logic [BUS_AW-1:0] A_OUTCFG  = 4'h5;
  localparam logic [BUS_AW-1:0] A_RELEASE = 4'h6;
  localparam logic [BUS_AW-1:0] A_MATCH0  = 4'h8;

  localparam int CFG_EN_LSB = 8;

  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } match_act_t;

  localparam int ACT_W = $bits(match_act_t);
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run,
  input  logic                            clr,
  input  logic                            pwm_mode,
  input  logic [CNT_W-1:0]                presc,
  input  logic [N_MATCH-1:0][CNT_W-1:0]   mval,
  input  logic [N_MATCH-1:0]              rst_mask,
  input  logic [N_MATCH-1:0]              stop_mask,
  output logic [CNT_W-1:0]                count,
  output logic [N_MATCH-1:0]              match_ev,
  output logic                            stop_ev
);
  logic [CNT_W-1:0] pc_q, pc_d, tc_q, tc_d;
  logic             pc_wrap, tick, rst_hit, stop_hit;

  always_comb begin
    pc_wrap = (pc_q >= presc);
    tick    = run && !clr && pc_wrap;
    for (int k = 0; k < N_MATCH; k++) begin
      match_ev[k] = tick && (tc_q == mval[k]);
    end
    rst_hit  = (|(match_ev & rst_mask)) || (pwm_mode && match_ev[0]);
    stop_hit = |(match_ev & stop_mask);
  end

  // prescaler next state
  always_comb begin
    pc_d = pc_q;
    if (clr) begin
      pc_d = '0;
    end else if (run) begin
      pc_d = pc_wrap ? '0 : pc_q + CNT_W'(1);
    end
  end

  // counter next state: clear > restart > halt > increment
  always_comb begin
    tc_d = tc_q;
    if (clr) begin
      tc_d = '0;
    end else if (tick) begin
      if (rst_hit) begin
        tc_d = '0;
      end else if (!stop_hit) begin
        tc_d = tc_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tc_q <= '0;
    end else begin
      pc_q <= pc_d;
      tc_q <= tc_d;
    end
  end

  assign count   = tc_q;
  assign stop_ev = stop_hit;

  AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R12
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count)); // R2
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && match_ev[0]) |=> (count == '0)); // R3
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pwm_mode,
  input  logic                            boundary,
  input  logic [N_MATCH-1:0]              wr_sel,
  input  logic [CNT_W-1:0]                wr_data,
  input  logic                            rel_wr,
  input  logic [N_MATCH-1:0]              rel_bits,
  output logic [N_MATCH-1:0][CNT_W-1:0]   shadow,
  output logic [N_MATCH-1:0][CNT_W-1:0]   active,
  output logic [N_MATCH-1:0]              pending
);
  logic [N_MATCH-1:0][CNT_W-1:0] sh_q, sh_d, act_q, act_d;
  logic [N_MATCH-1:0]            pend_q, pend_d;

  always_comb begin
    for (int k = 0; k < N_MATCH; k++) begin
      sh_d[k]  = wr_sel[k] ? wr_data : sh_q[k];
      act_d[k] = act_q[k];
      if (!pwm_mode && wr_sel[k]) begin
        act_d[k] = wr_data;
      end else if (pwm_mode && boundary && pend_q[k]) begin
        act_d[k] = sh_q[k];
      end
      if (!pwm_mode) begin
        pend_d[k] = 1'b0;
      end else begin
        pend_d[k] = (pend_q[k] && !boundary) || (rel_wr && rel_bits[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      act_q  <= '0;
      pend_q <= '0;
    end else begin
      sh_q   <= sh_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign shadow  = sh_q;
  assign active  = act_q;
  assign pending = pend_q;

  AST_ACTIVE_FROZEN_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !boundary) |=> $stable(active)); // R6
  AST_PENDING_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !rel_wr) |=> (pending == '0)); // R7
endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_on,
  input  logic dbl,
  input  logic ev_base,
  input  logic ev_lead,
  input  logic ev_trail,
  input  logic enable,
  output logic pin
);
  logic out_q, out_d, set_ev, rst_ev;

  always_comb begin
    set_ev = dbl ? ev_lead : ev_base;
    rst_ev = ev_trail;
    out_d  = out_q;
    if (!mode_on || rst_ev) begin
      out_d = 1'b0;
    end else if (set_ev) begin
      out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign pin = out_q & enable;

  AST_RESET_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> !out_q); // R5
  AST_SET_EDGE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && set_ev && !rst_ev) |=> out_q); // R4
endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_OUT = PWM_OUTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_OUT-1:0]  pwm_out,
  output logic              irq
);
  localparam int N_MATCH = N_OUT + 1;
  localparam int ACT_BITS = ACT_W * N_MATCH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  logic                          run_q, run_d, clr_q, clr_d, pwm_q, pwm_d;
  logic [CNT_W-1:0]              presc_q, presc_d;
  match_act_t [N_MATCH-1:0]      act_q, act_d;
  logic [N_MATCH-1:0]            flags_q, flags_d;
  logic [N_OUT-1:0]              dbl_q, dbl_d, oen_q, oen_d;

  logic                          wr, hit_ctrl, hit_presc, hit_action, hit_flags, hit_cfg, hit_rel;
  logic [N_MATCH-1:0]            wr_sel, rst_mask, stop_mask, irq_ev, flag_clr, match_ev, pending;
  logic [N_MATCH-1:0][CNT_W-1:0] shadow, active;
  logic [CNT_W-1:0]              count;
  logic                          stop_ev;

  always_comb begin
    wr         = bus_sel && bus_wr;
    hit_ctrl   = wr && (bus_addr == A_CTRL);
    hit_presc  = wr && (bus_addr == A_PRESC);
    hit_action = wr && (bus_addr == A_ACTION);
    hit_flags  = wr && (bus_addr == A_FLAGS);
    hit_cfg    = wr && (bus_addr == A_OUTCFG);
    hit_rel    = wr && (bus_addr == A_RELEASE);
    for (int k = 0; k < N_MATCH; k++) begin
      wr_sel[k]    = wr && (bus_addr == (A_MATCH0 + BUS_AW'(k)));
      rst_mask[k]  = act_q[k].rst;
      stop_mask[k] = act_q[k].stop;
      irq_ev[k]    = match_ev[k] && act_q[k].irq;
    end
  end

  // control register next state
  always_comb begin
    run_d   = run_q;
    clr_d   = clr_q;
    pwm_d   = pwm_q;
    presc_d = presc_q;
    act_d   = act_q;
    dbl_d   = dbl_q;
    oen_d   = oen_q;
    if (hit_ctrl) begin
      run_d = bus_wdata[0];
      clr_d = bus_wdata[1];
      pwm_d = bus_wdata[2];
    end
    if (stop_ev) begin
      run_d = 1'b0;
    end
    if (hit_presc) begin
      presc_d = bus_wdata;
    end
    if (hit_action) begin
      act_d = bus_wdata[ACT_BITS-1:0];
    end
    if (hit_cfg) begin
      dbl_d = bus_wdata[N_OUT-1:0];
      oen_d = bus_wdata[CFG_EN_LSB +: N_OUT];
    end
    flag_clr = hit_flags ? bus_wdata[N_MATCH-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | irq_ev;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q   <= 1'b0;
      clr_q   <= 1'b0;
      pwm_q   <= 1'b0;
      presc_q <= '0;
      act_q   <= '0;
      flags_q <= '0;
      dbl_q   <= '0;
      oen_q   <= '0;
    end else begin
      run_q   <= run_d;
      clr_q   <= clr_d;
      pwm_q   <= pwm_d;
      presc_q <= presc_d;
      act_q   <= act_d;
      flags_q <= flags_d;
      dbl_q   <= dbl_d;
      oen_q   <= oen_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:    bus_rdata[2:0] = {pwm_q, clr_q, run_q};
      A_PRESC:   bus_rdata = presc_q;
      A_COUNT:   bus_rdata = count;
      A_ACTION:  bus_rdata[ACT_BITS-1:0] = act_q;
      A_FLAGS:   bus_rdata[N_MATCH-1:0] = flags_q;
      A_OUTCFG:  begin
        bus_rdata[N_OUT-1:0]             = dbl_q;
        bus_rdata[CFG_EN_LSB +: N_OUT]   = oen_q;
      end
      A_RELEASE: bus_rdata[N_MATCH-1:0] = pending;
      default: begin
        for (int k = 0; k < N_MATCH; k++) begin
          if (bus_addr == (A_MATCH0 + BUS_AW'(k))) begin
            bus_rdata = shadow[k];
          end
        end
      end
    endcase
  end

  pwm_timebase #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run_q),
    .clr       (clr_q),
    .pwm_mode  (pwm_q),
    .presc     (presc_q),
    .mval      (active),
    .rst_mask  (rst_mask),
    .stop_mask (stop_mask),
    .count     (count),
    .match_ev  (match_ev),
    .stop_ev   (stop_ev)
  );

  pwm_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pwm_mode (pwm_q),
    .boundary (match_ev[0]),
    .wr_sel   (wr_sel),
    .wr_data  (bus_wdata),
    .rel_wr   (hit_rel),
    .rel_bits (bus_wdata[N_MATCH-1:0]),
    .shadow   (shadow),
    .active   (active),
    .pending  (pending)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_out
      pwm_edge_unit u_edge (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .mode_on  (pwm_q),
        .dbl      (dbl_q[gi]),
        .ev_base  (match_ev[0]),
        .ev_lead  (match_ev[gi]),
        .ev_trail (match_ev[gi+1]),
        .enable   (oen_q[gi]),
        .pin      (pwm_out[gi])
      );
    end
  endgenerate

  assign irq = |flags_q;

  AST_HALT_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_core_n)
    stop_ev |=> !run_q); // R11
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    !hit_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R10
  AST_TIMER_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    !pwm_q |=> (pwm_out == '0)); // R9
endmodule

// File: tb/pwm_dual_edge_bench.sv
module pwm_dual_edge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  pwm_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int hi[6];

  always #4 clk = ~clk;

  pwm_dual_edge u_pwm_dual_edge (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic measure(input int len);
    for (int i = 0; i < 6; i++) hi[i] = 0;
    repeat (len) begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) hi[i] += int'(pwm_out[i]);
    end
  endtask

  function automatic int exp_single(input int m, input int mr0);
    if (m < mr0) return m + 1;
    if (m == mr0) return 0;
    return mr0 + 1;
  endfunction

  function automatic int exp_double(input int a, input int b, input int p);
    if (a < b) return b - a;
    if (a > b) return p - (a - b);
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int mx, zeros, changes;
    logic [31:0] prev;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 15; a++) begin
      if (a == 7) continue;
      rd(4'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 0);
    end
    chk("R1 outputs", pwm_out, 0);
    chk("R1 irq", irq, 0);

    // R4 single-edge sweep, period 6
    wr(4'h1, 0);
    wr(4'h0, 32'h5);
    wr(4'h5, 32'h3F00);
    for (int m = 0; m < 8; m++) begin
      wr(4'h8, 5);
      for (int n = 1; n <= 6; n++) wr(4'(8 + n), 32'((m + n) % 8));
      wr(4'h6, 32'h7F);
      repeat (30) @(negedge clk);
      measure(6);
      for (int i = 0; i < 6; i++)
        chk($sformatf("R4 single out%0d m=%0d", i + 1, (m + i + 1) % 8), hi[i],
            exp_single((m + i + 1) % 8, 5));
    end

    // R5 double-edge sweep, period 8; outputs 2,4,6 double
    wr(4'h5, 32'h3F2A);
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int c;
        c = (a + b) % 8;
        wr(4'h8, 7);
        wr(4'h9, 32'(a)); wr(4'hA, 32'(b)); wr(4'hB, 32'(b));
        wr(4'hC, 32'(a)); wr(4'hD, 32'(a)); wr(4'hE, 32'(c));
        wr(4'h6, 32'h7F);
        repeat (32) @(negedge clk);
        measure(8);
        chk($sformatf("R4 out1 a=%0d", a), hi[0], exp_single(a, 7));
        chk($sformatf("R5 out2 a=%0d b=%0d", a, b), hi[1], exp_double(a, b, 8));
        chk($sformatf("R4 out3 b=%0d", b), hi[2], exp_single(b, 7));
        chk($sformatf("R5 out4 a=%0d b=%0d", b, a), hi[3], exp_double(b, a, 8));
        chk($sformatf("R4 out5 a=%0d", a), hi[4], exp_single(a, 7));
        chk($sformatf("R5 out6 a=%0d c=%0d", a, c), hi[5], exp_double(a, c, 8));
      end
    end

    // R3 count wraps at compare 0 (M0=7)
    mx = 0; zeros = 0;
    for (int t = 0; t < 16; t++) begin
      rd(4'h2, d);
      if (int'(d) > mx) mx = int'(d);
      if (d == 0) zeros++;
    end
    chk("R3 max count", mx, 7);
    chk("R3 wraps in 16", zeros, 2);

    // R2 prescaler: PRESC=2, M0=3, M1=1, all single-edge
    wr(4'h5, 32'h3F00);
    wr(4'h1, 2);
    wr(4'h8, 3); wr(4'h9, 1);
    wr(4'h6, 32'h03);
    repeat (60) @(negedge clk);
    measure(12);
    chk("R2 out1 high with prescale", hi[0], 6);
    rd(4'h2, prev); changes = 0; mx = int'(prev);
    for (int t = 0; t < 12; t++) begin
      rd(4'h2, d);
      if (d != prev) changes++;
      if (int'(d) > mx) mx = int'(d);
      prev = d;
    end
    chk("R2 count steps in 12 clocks", changes, 4);
    chk("R2 max count", mx, 3);
    wr(4'h1, 0);

    // R6 / R7 shadowing
    wr(4'h8, 7); wr(4'h9, 2);
    wr(4'h6, 32'h03);
    repeat (32) @(negedge clk);
    measure(8);
    chk("R6 baseline out1", hi[0], 3);
    wr(4'h9, 5);
    repeat (32) @(negedge clk);
    measure(8);
    chk("R6 unreleased write ignored", hi[0], 3);
    rd(4'h9, d);
    chk("R6 shadow readback", d, 5);
    rd(4'h6, d);
    chk("R7 nothing pending", d, 0);
    wr(4'h6, 32'h02);
    rd(4'h6, d);
    chk("R7 pending mark", d, 2);
    repeat (24) @(negedge clk);
    rd(4'h6, d);
    chk("R7 mark cleared", d, 0);
    measure(8);
    chk("R7 released value applied", hi[0], 6);
    wr(4'h9, 1); wr(4'hB, 4);
    wr(4'h6, 32'h08);
    repeat (32) @(negedge clk);
    measure(8);
    chk("R7 unreleased out1 kept", hi[0], 6);
    chk("R7 released out3", hi[2], 5);

    // R8 output enable
    wr(4'h5, 32'h3E00);
    repeat (4) @(negedge clk);
    measure(8);
    chk("R8 disabled out1", hi[0], 0);
    chk("R8 enabled out3", hi[2], 5);

    // R9 / R10 timer mode with interrupt and restart on compare 2
    wr(4'h0, 32'h2);
    wr(4'h3, 32'hC0);
    wr(4'hA, 5);
    wr(4'h4, 32'h7F);
    wr(4'h0, 32'h1);
    repeat (3) @(negedge clk);
    mx = 0;
    for (int t = 0; t < 14; t++) begin
      rd(4'h2, d);
      if (int'(d) > mx) mx = int'(d);
    end
    chk("R9 direct write restart value", mx, 5);
    chk("R9 outputs low in timer mode", pwm_out, 0);
    chk("R10 irq raised", irq, 1);
    rd(4'h4, d);
    chk("R10 flag bit", d, 4);
    wr(4'h3, 32'h80);
    wr(4'h4, 32'h04);
    repeat (2) @(negedge clk);
    chk("R10 irq cleared", irq, 0);
    rd(4'h4, d);
    chk("R10 flags cleared", d, 0);

    // R12 clear, R11 halt on compare 3
    wr(4'h3, 32'h800);
    wr(4'hB, 9);
    wr(4'h0, 32'h2);
    repeat (2) @(negedge clk);
    rd(4'h2, d);
    chk("R12 count cleared", d, 0);
    repeat (3) @(negedge clk);
    rd(4'h2, d);
    chk("R12 count held", d, 0);
    wr(4'h0, 32'h1);
    repeat (25) @(negedge clk);
    rd(4'h2, d);
    chk("R11 halted at match", d, 9);
    repeat (5) @(negedge clk);
    rd(4'h2, d);
    chk("R11 still halted", d, 9);
    rd(4'h0, d);
    chk("R11 run bit cleared", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule